// File: doc/BRIEF.md
# Multi-Stage Parallel Trigger Unit

This block decides when a logic-analyzer style capture should begin. It looks at a parallel bus of sampled channels each time a sample-enable pulse arrives and compares the bus against a small set of trigger stages. Each stage holds a channel mask, an expected value, an arm level and a start flag. A stage hits only when every channel its mask selects carries the expected bit, and only while the unit's trigger level has reached the stage's arm level.

The hits of all stages are OR-combined. A hit on a stage without the start flag raises the trigger level by one, which arms the next stages in the sequence. A hit on a stage with the start flag produces a one-cycle capture-start pulse, after which the unit ignores the bus until a synchronous clear re-arms it. Chaining two level stages this way lets software build edge triggers out of pure pattern matches, for example "channel 0 low, then channel 0 high".

Stages are loaded through a small write port that selects a stage and one of its three fields. Stage configuration survives a clear; only the level and the fired state are reset by it.

Top module: `ptrig_unit`

## Requirements
- R1: After reset the trigger level is 0, no capture-start pulse is present, and every stage has a zero mask, zero value, arm level 0 and no start flag, so no sample can fire.
- R2: A stage's pattern matches when each channel selected by a 1 in its mask equals the same bit of its value word; channels whose mask bit is 0 are ignored, and all selected channels must agree (AND).
- R3: A stage whose mask is all zeros never matches, whatever the bus carries.
- R4: A stage takes part only while its arm level is less than or equal to the current trigger level.
- R5: On a sample where some armed stage without the start flag matches and no start stage matches, the level rises by exactly one, saturating at NUM_STAGES-1 (3 by default).
- R6: On a sample where an armed start stage matches, cap_start_o is 1 for exactly the cycle after that sampling edge; the start takes priority and the level does not move on that sample.
- R7: Once the capture start has fired, further matches produce no pulse and leave the level unchanged until a clear.
- R8: clear_i returns the level to 0 and re-arms the start; it takes priority over a sample in the same cycle.
- R9: The trigger condition is the OR of the stages: a match on any one armed stage is enough, whatever the other stages see.
- R10: While smp_en_i is 0 the bus is ignored: no level change and no pulse.
- R11: A write with cfg_kind_i = 0 loads the mask, 1 loads the value, 2 loads the control word (arm level in cfg_data_i[1:0], start flag in cfg_data_i[2] for four stages), and 3 changes nothing; a write affects only samples taken after its clock edge.
- R12: A rising edge on channel 0 is caught by stage 0 (mask 1, value 0, arm 0, no start) followed by stage 1 (mask 1, value 1, arm 1, start): a steady high does not fire, a low then a high does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous re-arm: level to 0, fired state cleared |
| cfg_we_i | input | 1 | Stage configuration write strobe |
| cfg_sel_i | input | $clog2(NUM_STAGES) | Stage selected for the write |
| cfg_kind_i | input | 2 | Field written: 0 mask, 1 value, 2 control, 3 none |
| cfg_data_i | input | NUM_CH | Write data |
| smp_en_i | input | 1 | Sample-enable pulse; the bus is evaluated on cycles where it is 1 |
| smp_i | input | NUM_CH | Sampled channel bus |
| cap_start_o | output | 1 | One-cycle capture-start pulse |
| level_o | output | $clog2(NUM_STAGES) | Current trigger level |

## Verification
The assertions watch, on every cycle, the shape of the capture-start pulse and that it only follows a start event, that the level moves by at most one step and never beyond its ceiling, that idle cycles and clears act as specified, and that nothing fires or moves after the start until the next clear. What a given mask and value pattern should do (AND matching across channels, disabled stages, arm-level gating, OR across stages, priority of start over advance, the two-stage edge trigger, and the timing of configuration writes against a sample in the same cycle) can only be shown by the bench's scenarios against its reference model.

// File: rtl/ptrig_pkg.sv
package ptrig_pkg;

  typedef enum logic [1:0] {
    CFG_MASK  = 2'd0,
    CFG_VALUE = 2'd1,
    CFG_CTRL  = 2'd2,
    CFG_NONE  = 2'd3
  } cfg_kind_e;

  // Pattern test on a bus padded to 32 bits: all masked bits equal, mask non-zero.
  function automatic logic pattern_hit(input logic [31:0] bus,
                                       input logic [31:0] value,
                                       input logic [31:0] mask);
    return (mask != 32'd0) && (((bus ^ value) & mask) == 32'd0);
  endfunction

  // One level step with saturation at the ceiling.
  function automatic logic [7:0] level_step(input logic [7:0] lvl,
                                            input logic [7:0] ceiling);
    return (lvl >= ceiling) ? ceiling : lvl + 8'd1;
  endfunction

endpackage

// File: rtl/ptrig_stage.sv
module ptrig_stage
  import ptrig_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [NUM_CH-1:0] wr_data,
  input  logic [NUM_CH-1:0] bus,
  input  logic [LVL_W-1:0]  level,
  output logic              hit_o,
  output logic              start_o
);

  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] value_q;
  logic [LVL_W-1:0]  arm_q;
  logic              start_q;
  logic              armed;
  logic              pat_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      value_q <= '0;
      arm_q   <= '0;
      start_q <= 1'b0;
    end else if (wr_en) begin
      case (cfg_kind_e'(wr_kind))
        CFG_MASK:  mask_q  <= wr_data;
        CFG_VALUE: value_q <= wr_data;
        CFG_CTRL: begin
          arm_q   <= wr_data[LVL_W-1:0];
          start_q <= wr_data[LVL_W];
        end
        default: ;
      endcase
    end
  end

  assign armed   = (arm_q <= level);
  assign pat_ok  = pattern_hit(32'(bus), 32'(value_q), 32'(mask_q));
  assign hit_o   = armed && pat_ok;
  assign start_o = start_q;

endmodule

// File: rtl/ptrig_seq.sv
module ptrig_seq
  import ptrig_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int LVL_W      = 2,
  parameter int MAX_LEVEL  = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear_i,
  input  logic                  smp_en_i,
  input  logic [NUM_STAGES-1:0] hit,
  input  logic [NUM_STAGES-1:0] is_start,
  output logic                  start_evt,
  output logic                  adv_evt,
  output logic                  cap_start_o,
  output logic [LVL_W-1:0]      level_o
);

  logic [LVL_W-1:0] level_q;
  logic [LVL_W-1:0] level_nx;
  logic             fired_q;
  logic             cap_q;

  assign start_evt = smp_en_i && |(hit & is_start);
  assign adv_evt   = smp_en_i && |(hit & ~is_start);
  assign level_nx  = LVL_W'(level_step(8'(level_q), 8'(MAX_LEVEL)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      fired_q <= 1'b0;
      cap_q   <= 1'b0;
    end else if (clear_i) begin
      level_q <= '0;
      fired_q <= 1'b0;
      cap_q   <= 1'b0;
    end else begin
      cap_q <= 1'b0;
      if (!fired_q) begin
        if (start_evt) begin
          cap_q   <= 1'b1;
          fired_q <= 1'b1;
        end else if (adv_evt) begin
          level_q <= level_nx;
        end
      end
    end
  end

  assign cap_start_o = cap_q;
  assign level_o     = level_q;

endmodule

// File: rtl/ptrig_unit.sv
module ptrig_unit
  import ptrig_pkg::*;
#(
  parameter int NUM_CH     = 32,
  parameter int NUM_STAGES = 4,
  localparam int SEL_W     = $clog2(NUM_STAGES),
  localparam int LVL_W     = $clog2(NUM_STAGES),
  localparam int MAX_LEVEL = NUM_STAGES - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cfg_we_i,
  input  logic [SEL_W-1:0]  cfg_sel_i,
  input  logic [1:0]        cfg_kind_i,
  input  logic [NUM_CH-1:0] cfg_data_i,
  input  logic              smp_en_i,
  input  logic [NUM_CH-1:0] smp_i,
  output logic              cap_start_o,
  output logic [LVL_W-1:0]  level_o
);

  logic [NUM_STAGES-1:0] stage_hit;
  logic [NUM_STAGES-1:0] stage_start;
  logic                  start_evt;
  logic                  adv_evt;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    logic wr_this;
    assign wr_this = cfg_we_i && (cfg_sel_i == SEL_W'(s));
    ptrig_stage #(.NUM_CH(NUM_CH), .LVL_W(LVL_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_this),
      .wr_kind (cfg_kind_i),
      .wr_data (cfg_data_i),
      .bus     (smp_i),
      .level   (level_o),
      .hit_o   (stage_hit[s]),
      .start_o (stage_start[s])
    );
  end

  ptrig_seq #(.NUM_STAGES(NUM_STAGES), .LVL_W(LVL_W), .MAX_LEVEL(MAX_LEVEL)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .smp_en_i    (smp_en_i),
    .hit         (stage_hit),
    .is_start    (stage_start),
    .start_evt   (start_evt),
    .adv_evt     (adv_evt),
    .cap_start_o (cap_start_o),
    .level_o     (level_o)
  );

endmodule

// File: rtl/ptrig_unit_chk.sv
module ptrig_unit_chk #(
  parameter int LVL_W     = 2,
  parameter int MAX_LEVEL = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_i,
  input logic             smp_en_i,
  input logic             cap_start_o,
  input logic [LVL_W-1:0] level_o,
  input logic             start_evt,
  input logic             adv_evt
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else if (clear_i) seen_q <= 1'b0;
    else if (cap_start_o) seen_q <= 1'b1;
  end

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_start_o |=> !cap_start_o);

  assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_start_o |-> ($past(start_evt) && !$past(clear_i)));

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level_o) <= MAX_LEVEL);

  assert_level_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (32'(level_o) == 32'($past(level_o)) || 32'(level_o) == 32'($past(level_o)) + 1));

  assert_adv_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !start_evt && !clear_i && !seen_q && !cap_start_o && 32'(level_o) < MAX_LEVEL)
      |=> 32'(level_o) == 32'($past(level_o)) + 1);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_en_i && !clear_i) |=> ($stable(level_o) && !cap_start_o));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (level_o == '0 && !cap_start_o));

  assert_no_refire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> !cap_start_o);

  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !clear_i) |=> $stable(level_o));

endmodule

bind ptrig_unit ptrig_unit_chk #(.LVL_W(LVL_W), .MAX_LEVEL(MAX_LEVEL)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clear_i     (clear_i),
  .smp_en_i    (smp_en_i),
  .cap_start_o (cap_start_o),
  .level_o     (level_o),
  .start_evt   (start_evt),
  .adv_evt     (adv_evt)
);

// File: tb/test_ptrig_unit.sv
`timescale 1ns/1ps
module test_ptrig_unit;
  localparam int NCH = 32;
  localparam int NST = 4;
  localparam int TOP = NST - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear_i = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [1:0] cfg_sel_i = '0;
  logic [1:0] cfg_kind_i = '0;
  logic [NCH-1:0] cfg_data_i = '0;
  logic smp_en_i = 1'b0;
  logic [NCH-1:0] smp_i = '0;
  logic cap_start_o;
  logic [1:0] level_o;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #4 clk = ~clk;

  ptrig_unit #(.NUM_CH(NCH), .NUM_STAGES(NST)) i_ptrig_unit (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .cfg_we_i(cfg_we_i),
    .cfg_sel_i(cfg_sel_i), .cfg_kind_i(cfg_kind_i), .cfg_data_i(cfg_data_i),
    .smp_en_i(smp_en_i), .smp_i(smp_i), .cap_start_o(cap_start_o), .level_o(level_o)
  );

  // Behavioural reference model
  int unsigned r_mask[NST];
  int unsigned r_val[NST];
  int r_arm[NST];
  bit r_go[NST];
  int r_lvl = 0;
  bit r_done = 0;
  bit r_cap = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      r_lvl = 0; r_done = 0; r_cap = 0;
      for (int s = 0; s < NST; s++) begin
        r_mask[s] = 0; r_val[s] = 0; r_arm[s] = 0; r_go[s] = 0;
      end
    end else begin
      bit want_go;
      bit want_up;
      want_go = 0; want_up = 0;
      if (smp_en_i) begin
        for (int s = 0; s < NST; s++) begin
          bit ok;
          ok = (r_mask[s] != 0) && (r_arm[s] <= r_lvl);
          for (int b = 0; b < NCH; b++)
            if (r_mask[s][b] && (smp_i[b] != r_val[s][b])) ok = 0;
          if (ok) begin
            if (r_go[s]) want_go = 1; else want_up = 1;
          end
        end
      end
      r_cap = 0;
      if (clear_i) begin
        r_lvl = 0; r_done = 0;
      end else if (!r_done) begin
        if (want_go) begin r_cap = 1; r_done = 1; end
        else if (want_up && r_lvl < TOP) r_lvl = r_lvl + 1;
      end
      if (cfg_we_i) begin
        case (cfg_kind_i)
          2'd0: r_mask[cfg_sel_i] = cfg_data_i;
          2'd1: r_val[cfg_sel_i] = cfg_data_i;
          2'd2: begin r_arm[cfg_sel_i] = cfg_data_i % 4; r_go[cfg_sel_i] = cfg_data_i[2]; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_cmp++;
      if (cap_start_o !== r_cap || int'(level_o) != r_lvl) begin
        n_bad++;
        $display("FAIL %s model: cap=%0b level=%0d expected cap=%0b level=%0d",
                 cur_req, cap_start_o, level_o, r_cap, r_lvl);
      end
    end
  end

  task automatic check(input string req, input bit cap_exp, input int lvl_exp);
    n_cmp++;
    if (cap_start_o !== cap_exp || int'(level_o) != lvl_exp) begin
      n_bad++;
      $display("FAIL %s: cap=%0b level=%0d expected cap=%0b level=%0d",
               req, cap_start_o, level_o, cap_exp, lvl_exp);
    end
  endtask

  task automatic wr(input int s, input int kind, input logic [NCH-1:0] d);
    @(negedge clk);
    cfg_we_i = 1; cfg_sel_i = 2'(s); cfg_kind_i = 2'(kind); cfg_data_i = d;
    @(negedge clk);
    cfg_we_i = 0;
  endtask

  task automatic set_stage(input int s, input logic [NCH-1:0] m, input logic [NCH-1:0] v,
                           input int arm, input bit go);
    wr(s, 0, m);
    wr(s, 1, v);
    wr(s, 2, NCH'(arm % 4) | (go ? NCH'(4) : NCH'(0)));
  endtask

  task automatic wipe();
    for (int s = 0; s < NST; s++) set_stage(s, '0, '0, 0, 0);
  endtask

  task automatic smp(input logic [NCH-1:0] d);
    @(negedge clk);
    smp_en_i = 1; smp_i = d;
    @(negedge clk);
    smp_en_i = 0;
  endtask

  task automatic clr();
    @(negedge clk);
    clear_i = 1;
    @(negedge clk);
    clear_i = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R1"; check("R1 reset", 0, 0);
    smp('1); check("R1 unconfigured all ones", 0, 0);
    smp('0); check("R3 zero masks", 0, 0);

    cur_req = "R2";
    set_stage(0, 32'h0000_000F, 32'h0000_0005, 0, 1);
    smp(32'h0000_00F4); check("R2 one masked bit off", 0, 0);
    smp(32'hFFFF_FFA5); check("R2 match ignores unmasked", 1, 0);
    @(negedge clk); check("R6 pulse single cycle", 0, 0);
    cur_req = "R7";
    smp(32'h0000_0005); check("R7 no refire", 0, 0);

    cur_req = "R8"; clr(); check("R8 clear", 0, 0);
    cur_req = "R10";
    @(negedge clk); smp_i = 32'h5; smp_en_i = 0;
    repeat (3) @(negedge clk);
    check("R10 disabled sample", 0, 0);

    cur_req = "R12"; clr(); wipe();
    set_stage(0, 32'h1, 32'h0, 0, 0);
    set_stage(1, 32'h1, 32'h1, 1, 1);
    smp(32'h1); check("R4 R12 high without low", 0, 0);
    smp(32'h1); check("R12 steady high", 0, 0);
    smp(32'h0); check("R12 low advances", 0, 1);
    smp(32'h1); check("R12 rising edge fires", 1, 1);
    smp(32'h0); check("R7 level frozen", 0, 1);

    cur_req = "R5"; clr(); wipe();
    set_stage(0, 32'h1, 32'h0, 0, 0);
    smp(32'h0); check("R5 step 1", 0, 1);
    smp(32'h0); check("R5 step 2", 0, 2);
    smp(32'h0); check("R5 step 3", 0, 3);
    smp(32'h0); check("R5 saturate", 0, 3);
    smp(32'h1); check("R5 no match holds", 0, 3);

    cur_req = "R4"; clr(); wipe();
    set_stage(2, 32'h2, 32'h2, 2, 1);
    smp(32'h2); check("R4 unarmed stage", 0, 0);

    cur_req = "R9"; clr(); wipe();
    set_stage(0, 32'h80, 32'h80, 0, 1);
    set_stage(3, 32'h01, 32'h01, 0, 1);
    smp(32'h01); check("R9 second stage alone", 1, 0);

    cur_req = "R6"; clr(); wipe();
    set_stage(0, 32'h1, 32'h1, 0, 0);
    set_stage(1, 32'h2, 32'h2, 0, 1);
    smp(32'h3); check("R6 start beats advance", 1, 0);

    cur_req = "R8"; clr(); wipe();
    set_stage(0, 32'h4, 32'h4, 0, 1);
    @(negedge clk); clear_i = 1; smp_en_i = 1; smp_i = 32'h4;
    @(negedge clk); clear_i = 0; smp_en_i = 0;
    check("R8 clear beats sample", 0, 0);

    cur_req = "R11"; clr(); wipe();
    set_stage(0, 32'h1, 32'h1, 0, 1);
    wr(0, 3, 32'h0);
    smp(32'h1); check("R11 kind 3 ignored", 1, 0);
    clr();
    @(negedge clk);
    cfg_we_i = 1; cfg_sel_i = 0; cfg_kind_i = 1; cfg_data_i = 32'h0;
    smp_en_i = 1; smp_i = 32'h0;
    @(negedge clk); cfg_we_i = 0; smp_en_i = 0;
    check("R11 write not seen by same sample", 0, 0);
    smp(32'h0); check("R11 write seen afterwards", 1, 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule